// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider

This block forms the digital feedback path of an integer-N frequency synthesizer. A dual-modulus prescaler running on the oscillator clock divides by 32 or 33. A main counter and a swallow counter sit behind it, and together the three divide the oscillator clock by N = 32·SMC + SSC. SMC is chosen from 86 to 89 by a 2-bit code, and SSC is a 5-bit swallow value. A second counter divides the reference clock so that both supported reference frequencies, 10.368 MHz and 13.824 MHz, give the same 1.728 MHz comparison rate.

Each divider emits a pulse one cycle wide in its own clock domain, once per output period. The two pulses go to an external phase detector. New settings are sampled only at an output-period boundary. A control processor can therefore rewrite the channel at any time, and no period is ever shortened.

Top module: `synth_div`

## Requirements
- R1: While `rst_n` is low, `ref_pulse` and `fb_pulse` are 0. The first feedback period after reset release runs with code 00 and swallow 0, which is 2752 oscillator cycles, whatever the inputs hold.
- R2: `ref_pulse` repeats every 6 reference cycles when the active `ref_sel` is 0, and every 8 when it is 1.
- R3: `fb_pulse` repeats every 32·SMC + SSC oscillator cycles. SMC is 86, 87, 88 or 89 for `mc_code` 00, 01, 10 or 11, and SSC is the unsigned value of `swallow`.
- R4: The swallow extremes 0 and 31 give N = 32·SMC and N = 32·SMC + 31. The lowest and highest settings in use (86/27, N = 2779, and 89/26, N = 2874) divide exactly.
- R5: Each `ref_pulse` and `fb_pulse` lasts exactly one cycle of its own clock.
- R6: A change of `mc_code`, `swallow` or `ref_sel` has no effect on the period in progress. The value present at the clock edge that raises the pulse governs the period that begins there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ref_sel | input | 1 | 0: reference divide by 6, 1: divide by 8 |
| mc_code | input | 2 | Main-counter code, SMC = 86 + code |
| swallow | input | 5 | Swallow count SSC, 0 to 31 |
| ref_pulse | output | 1 | Divided reference pulse, one ref_clk cycle |
| fb_pulse | output | 1 | Divided feedback pulse, one vco_clk cycle |

## Verification
The feedback divider is run through the four corner codes with swallow 0 and 31, and through the two extreme channel settings. Together these show the main-code mapping apart from the swallow contribution. Seeded random codes follow, some changed in mid-period, to separate the boundary sampling from immediate pickup. The reference divider gets steady runs of each select value, strict alternation and mid-period toggles. Every interval is measured in clock cycles between pulses and compared with a closed-form figure.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int PRE_LO    = 32;
  localparam int MC_BASE   = 86;
  localparam int MC_CODE_W = 2;
  localparam int SW_W      = 5;
  localparam int REF_DIV0  = 6;
  localparam int REF_DIV1  = 8;
  localparam int MC_W      = $clog2(MC_BASE + (1 << MC_CODE_W));
  localparam int PS_W      = $clog2(PRE_LO + 1);
  localparam int REF_W     = $clog2(REF_DIV1);
  localparam int N_W       = $clog2(PRE_LO * (MC_BASE + (1 << MC_CODE_W)) + 1);

  function automatic logic [MC_W-1:0] main_ratio(input logic [MC_CODE_W-1:0] code);
    return MC_W'(MC_BASE) + MC_W'(code);
  endfunction

  function automatic logic [N_W-1:0] fb_ratio(input logic [MC_CODE_W-1:0] code,
                                               input logic [SW_W-1:0] sw);
    return N_W'(PRE_LO) * N_W'(main_ratio(code)) + N_W'(sw);
  endfunction

  function automatic logic [REF_W-1:0] ref_last(input logic sel);
    return sel ? REF_W'(REF_DIV1 - 1) : REF_W'(REF_DIV0 - 1);
  endfunction
endpackage

// File: rtl/sd_ref_divider.sv
module sd_ref_divider
  import synth_div_pkg::*;
#(
  parameter int RW = REF_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  output logic wrap_o,
  output logic pulse_o
);
  logic [RW-1:0] cnt;
  logic          act_sel;

  assign wrap_o = (cnt == RW'(ref_last(act_sel)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_sel <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= wrap_o;
      if (wrap_o) begin
        cnt     <= '0;
        act_sel <= sel_i;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sd_prescaler.sv
module sd_prescaler
  import synth_div_pkg::*;
#(
  parameter int PRE_MOD = PRE_LO,
  parameter int PW      = PS_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_hi_i,
  output logic tick_o
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] last;

  assign last   = mod_hi_i ? PW'(PRE_MOD) : PW'(PRE_MOD - 1);
  assign tick_o = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick_o) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sd_swallow_ctrl.sv
module sd_swallow_ctrl
  import synth_div_pkg::*;
#(
  parameter int CW = MC_CODE_W,
  parameter int SW = SW_W,
  parameter int MW = MC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [CW-1:0] code_i,
  input  logic [SW-1:0] sw_i,
  output logic          mod_hi_o,
  output logic          cycle_end_o,
  output logic          pulse_o,
  output logic [CW-1:0] act_code_o,
  output logic [SW-1:0] act_sw_o,
  output logic [MW-1:0] m_left_o,
  output logic [SW-1:0] s_left_o
);
  assign mod_hi_o    = (s_left_o != '0);
  assign cycle_end_o = tick_i && (m_left_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left_o   <= MW'(MC_BASE - 1);
      s_left_o   <= '0;
      act_code_o <= '0;
      act_sw_o   <= '0;
      pulse_o    <= 1'b0;
    end else begin
      pulse_o <= cycle_end_o;
      if (cycle_end_o) begin
        m_left_o   <= main_ratio(code_i) - 1'b1;
        s_left_o   <= sw_i;
        act_code_o <= code_i;
        act_sw_o   <= sw_i;
      end else if (tick_i) begin
        m_left_o <= m_left_o - 1'b1;
        if (s_left_o != '0) s_left_o <= s_left_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_div.sv
module synth_div
  import synth_div_pkg::*;
(
  input  logic                 ref_clk,
  input  logic                 vco_clk,
  input  logic                 rst_n,
  input  logic                 ref_sel,
  input  logic [MC_CODE_W-1:0] mc_code,
  input  logic [SW_W-1:0]      swallow,
  output logic                 ref_pulse,
  output logic                 fb_pulse
);
  logic                 ref_wrap;
  logic                 pre_tick;
  logic                 mod_hi;
  logic                 cycle_end;
  logic [MC_CODE_W-1:0] act_code;
  logic [SW_W-1:0]      act_sw;
  logic [MC_W-1:0]      m_left;
  logic [SW_W-1:0]      s_left;

  sd_ref_divider u_ref (
    .clk(ref_clk), .rst_n(rst_n), .sel_i(ref_sel),
    .wrap_o(ref_wrap), .pulse_o(ref_pulse)
  );

  sd_prescaler u_pre (
    .clk(vco_clk), .rst_n(rst_n), .mod_hi_i(mod_hi), .tick_o(pre_tick)
  );

  sd_swallow_ctrl u_ctl (
    .clk(vco_clk), .rst_n(rst_n), .tick_i(pre_tick),
    .code_i(mc_code), .sw_i(swallow),
    .mod_hi_o(mod_hi), .cycle_end_o(cycle_end), .pulse_o(fb_pulse),
    .act_code_o(act_code), .act_sw_o(act_sw),
    .m_left_o(m_left), .s_left_o(s_left)
  );
endmodule

// File: rtl/synth_div_chk.sv
module synth_div_chk
  import synth_div_pkg::*;
(
  input logic                 ref_clk,
  input logic                 vco_clk,
  input logic                 rst_n,
  input logic                 ref_pulse,
  input logic                 fb_pulse,
  input logic                 pre_tick,
  input logic                 mod_hi,
  input logic                 cycle_end,
  input logic [MC_CODE_W-1:0] act_code,
  input logic [SW_W-1:0]      act_sw,
  input logic [MC_W-1:0]      m_left,
  input logic [SW_W-1:0]      s_left
);
  logic [N_W-1:0] gap;
  logic [3:0]     ref_gap;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (cycle_end) gap <= '0;
    else gap <= gap + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_gap <= '0;
    else if (ref_pulse) ref_gap <= 4'd1;
    else ref_gap <= ref_gap + 1'b1;
  end

  a_r5_fb_single: assert property (@(posedge vco_clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  a_r5_ref_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  a_r3_period: assert property (@(posedge vco_clk) disable iff (!rst_n)
    cycle_end |-> (gap == fb_ratio(act_code, act_sw) - 1'b1));

  a_r3_swallow_bound: assert property (@(posedge vco_clk) disable iff (!rst_n)
    ({2'b00, s_left} <= m_left + 1'b1));

  a_r3_mod_at_tick: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (mod_hi != $past(mod_hi)) |-> $past(pre_tick));

  a_r6_cfg_hold: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$past(cycle_end) |-> ($stable(act_code) && $stable(act_sw)));

  a_r2_ref_gap: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_gap <= 4'd8);
endmodule

bind synth_div synth_div_chk u_chk (
  .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
  .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
  .pre_tick(pre_tick), .mod_hi(mod_hi), .cycle_end(cycle_end),
  .act_code(act_code), .act_sw(act_sw), .m_left(m_left), .s_left(s_left)
);

// File: tb/tb_synth_div.sv
module tb_synth_div;
  logic       ref_clk = 1'b0;
  logic       vco_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       ref_sel = 1'b0;
  logic [1:0] mc_code = 2'd0;
  logic [4:0] swallow = 5'd0;
  logic       ref_pulse, fb_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 vco_clk = ~vco_clk;
  always #5 ref_clk = ~ref_clk;

  synth_div dut (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .ref_sel(ref_sel),
    .mc_code(mc_code), .swallow(swallow),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse)
  );

  function automatic int exp_fb(input logic [1:0] c, input logic [4:0] s);
    return ((int'(c) + 86) << 5) | int'(s);
  endfunction

  function automatic int exp_ref(input logic s);
    return s ? 8 : 6;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts vco cycles from the current negedge to the next fb pulse;
  // optionally drives new settings in mid-period (R6)
  task automatic measure_fb(output int n, input bit mid,
                            input logic [1:0] mc, input logic [4:0] ms);
    n = 0;
    do begin
      @(negedge vco_clk);
      n++;
      if (n == 1) check("R5 fb width", int'(fb_pulse), 0);
      if (mid && n == 1000) begin mc_code = mc; swallow = ms; end
    end while (!fb_pulse && n < 4000);
  endtask

  task automatic measure_ref(output int n, input bit mid);
    n = 0;
    do begin
      @(negedge ref_clk);
      n++;
      if (n == 1) check("R5 ref width", int'(ref_pulse), 0);
      if (mid && n == 3) ref_sel = ~ref_sel;
    end while (!ref_pulse && n < 20);
  endtask

  task automatic fb_run();
    logic [1:0] dc [8] = '{2'd0, 2'd0, 2'd3, 2'd3, 2'd0, 2'd3, 2'd1, 2'd2};
    logic [4:0] ds [8] = '{5'd0, 5'd31, 5'd0, 5'd31, 5'd27, 5'd26, 5'd13, 5'd5};
    logic [1:0] ec;
    logic [4:0] es;
    int n;
    ec = mc_code; es = swallow;
    for (int i = 0; i < 48; i++) begin
      logic [1:0] nc;
      logic [4:0] ns;
      bit mid;
      if (i < 8) begin nc = dc[i]; ns = ds[i]; mid = 1'b0; end
      else begin
        nc = 2'($urandom_range(0, 3)); ns = 5'($urandom_range(0, 31));
        mid = (i % 4 == 0);
      end
      mc_code = nc; swallow = ns;
      measure_fb(n, mid, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)));
      if (mid) check("R6 fb change held to boundary", n, exp_fb(ec, es));
      else if (es == 5'd0 || es == 5'd31) check("R4 swallow extreme", n, exp_fb(ec, es));
      else if ((ec == 2'd0 && es == 5'd27) || (ec == 2'd3 && es == 5'd26))
        check("R4 channel extreme", n, exp_fb(ec, es));
      else check("R3 fb period", n, exp_fb(ec, es));
      ec = mc_code; es = swallow;
    end
  endtask

  task automatic ref_run();
    logic es;
    int n;
    measure_ref(n, 1'b0);
    es = ref_sel;
    for (int i = 0; i < 60; i++) begin
      bit mid;
      mid = 1'b0;
      if (i < 10) ref_sel = 1'b0;
      else if (i < 20) ref_sel = 1'b1;
      else if (i < 40) ref_sel = ~ref_sel;
      else begin ref_sel = 1'($urandom_range(0, 1)); mid = (i % 3 == 0); end
      measure_ref(n, mid);
      if (mid) check("R6 ref change held to boundary", n, exp_ref(es));
      else check("R2 ref period", n, exp_ref(es));
      es = ref_sel;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd2406));
    mc_code = 2'd3; swallow = 5'd31; ref_sel = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge vco_clk);
      check("R1 fb low in reset", int'(fb_pulse), 0);
      check("R1 ref low in reset", int'(ref_pulse), 0);
    end
    rst_n = 1'b1;
    fork
      begin
        measure_fb(n, 1'b0, 2'd0, 5'd0);
        check("R1 first fb period", n, 2752);
        fb_run();
      end
      ref_run();
    join
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule